// File: doc/BRIEF.md
# Zero-Turnaround Synchronous Burst SRAM

This block is a single-port synchronous static RAM on a shared bidirectional data bus. Address, command and chip selects are registered on the rising clock edge. A read places its data on the bus in the data slot two enabled edges after the read was issued. A write takes its data and byte masks from the bus in that same slot. Because reads and writes use the same slot, a read and a write can follow each other on any cycle without an idle turnaround cycle.

A loaded command can run as a four-beat burst. A 2-bit counter steps the low address bits in either interleaved (XOR) or linear (wrapping add) order. An active-low clock enable freezes every internal register. An asynchronous output enable can force the bus to high impedance at any time. The configuration of 65,536 words by 32 bits is `ADDR_W = 16`. The default `ADDR_W = 10` keeps the array small for elaboration.

Top module: `zbt_sram`

## Requirements
- R1: After reset no access is pending and the block leaves `dq` undriven until it receives a valid read.
- R2: A read loaded on enabled edge k drives the word at its address on `dq` from enabled edge k+1 until the next enabled edge, so the host samples it at edge k+2.
- R3: A write loaded on enabled edge k stores the `dq` value and `be_n` that are present at enabled edge k+2.
- R4: Each `be_n[i]` is active-low and gates `dq[8i+7:8i]`: bit 0 gates bits 7:0, bit 1 gates 15:8, bit 2 gates 23:16 and bit 3 gates 31:24. A byte whose enable is high keeps its old contents.
- R5: With `burst_lin` = 0 (interleaved), advance number n (1..3) of a burst accesses the loaded address with its two low bits XORed with n.
- R6: With `burst_lin` = 1 (linear), advance n accesses the loaded address with its two low bits replaced by (low bits + n) mod 4. The bits above bit 1 stay those of the loaded address.
- R7: `burst_adv` = 1 repeats the last loaded read or write at the next burst address. The count is 2 bits wide, so the fourth advance returns to the loaded address.
- R8: With `cen_n` = 1 the block ignores every synchronous input and holds all pipeline, burst and output state. The bus keeps its current value.
- R9: A load (`burst_adv` = 0) starts an access only when all three bits of `cs_n` are low. Otherwise the slot stays idle, nothing is written, and later advances stay idle until the next selected load.
- R10: Reads and writes can be issued on consecutive enabled edges in any mix, with no idle cycle between them.
- R11: A read issued on the edge right after a write to the same address returns the newly written bytes, merged by the write's byte enables, with the older contents in the masked bytes.
- R12: `oe_n` = 1 puts `dq` into high impedance at once and has no effect on the pipeline or stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cen_n | input | 1 | Active-low clock enable; high stalls the block |
| burst_adv | input | 1 | 0 loads a new address and command, 1 advances the burst |
| we_n | input | 1 | At load: 0 write, 1 read |
| cs_n | input | NCS | Active-low chip selects; all must be low to select |
| be_n | input | DATA_W/8 | Active-low byte write enables, sampled in the data slot |
| burst_lin | input | 1 | Burst order: 0 interleaved, 1 linear |
| addr | input | ADDR_W | Word address, sampled at load |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq | inout | DATA_W | Shared data bus |

## Verification
A wrong burst offset or upper address stays hidden until that word is read back. It then shows as a wrong word in the read slot two enabled edges after the read. A pipeline slip by one stage shows in the first slot after a read-to-write switch: either the bus is driven while the host drives write data, or read data arrives one slot early or late. A stall that leaks state shows as changed bus contents during the frozen cycles. A broken write-to-read bypass shows only when the read directly follows a write to the same address, and it returns stale bytes in that read slot.

// File: rtl/zbt_pkg.sv
`timescale 1ns/1ps
package zbt_pkg;

  // width of the in-burst counter (four beats)
  localparam int CNT_W = 2;

  typedef enum logic {
    ORD_INTERLEAVE = 1'b0,
    ORD_LINEAR     = 1'b1
  } burst_ord_e;

  // low address bits for a given beat of a burst
  function automatic logic [CNT_W-1:0] burst_offset(
    input logic [CNT_W-1:0] start,
    input logic [CNT_W-1:0] step,
    input burst_ord_e       ord
  );
    logic [CNT_W-1:0] res;
    if (ord == ORD_LINEAR) res = start + step;
    else                   res = start ^ step;
    return res;
  endfunction

endpackage

// File: rtl/zbt_burst_ctrl.sv
`timescale 1ns/1ps
module zbt_burst_ctrl
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int NCS    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              adv,
  input  logic              we_n,
  input  logic [NCS-1:0]    cs_n,
  input  logic [ADDR_W-1:0] addr,
  input  burst_ord_e        ord,
  output logic              a_vld,
  output logic              a_wr,
  output logic [ADDR_W-1:0] a_addr
);

  logic              cmd_vld_q, cmd_vld_d;
  logic              cmd_wr_q,  cmd_wr_d;
  logic [ADDR_W-1:0] base_q,    base_d;
  logic [CNT_W-1:0]  cnt_q,     cnt_d;
  logic [CNT_W-1:0]  cnt_step;
  logic              sel_ok;

  assign cnt_step = cnt_q + 1'b1;
  assign sel_ok   = ~|cs_n;

  // access presented to the pipeline at this edge
  always_comb begin
    if (!adv) begin
      a_vld  = sel_ok;
      a_wr   = ~we_n;
      a_addr = addr;
    end else begin
      a_vld  = cmd_vld_q;
      a_wr   = cmd_wr_q;
      a_addr = {base_q[ADDR_W-1:CNT_W],
                burst_offset(base_q[CNT_W-1:0], cnt_step, ord)};
    end
  end

  // next-state for the burst command registers
  always_comb begin
    cmd_vld_d = cmd_vld_q;
    cmd_wr_d  = cmd_wr_q;
    base_d    = base_q;
    cnt_d     = cnt_q;
    if (en) begin
      if (!adv) begin
        cmd_vld_d = sel_ok;
        cmd_wr_d  = ~we_n;
        base_d    = addr;
        cnt_d     = '0;
      end else begin
        cnt_d     = cnt_step;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_vld_q <= 1'b0;
      cmd_wr_q  <= 1'b0;
      base_q    <= '0;
      cnt_q     <= '0;
    end else begin
      cmd_vld_q <= cmd_vld_d;
      cmd_wr_q  <= cmd_wr_d;
      base_q    <= base_d;
      cnt_q     <= cnt_d;
    end
  end

  // R7
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && adv) |=> (cnt_q == $past(cnt_q) + 2'd1));

  // R9
  desel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !adv && (|cs_n)) |=> (!cmd_vld_q));

endmodule

// File: rtl/zbt_pipe.sv
`timescale 1ns/1ps
module zbt_pipe #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              a_vld,
  input  logic              a_wr,
  input  logic [ADDR_W-1:0] a_addr,
  output logic              s1_vld,
  output logic              s1_wr,
  output logic [ADDR_W-1:0] s1_addr,
  output logic              s2_vld,
  output logic              s2_wr,
  output logic [ADDR_W-1:0] s2_addr
);

  logic              s1_vld_d, s1_wr_d, s2_vld_d, s2_wr_d;
  logic [ADDR_W-1:0] s1_addr_d, s2_addr_d;

  always_comb begin
    s1_vld_d  = s1_vld;
    s1_wr_d   = s1_wr;
    s1_addr_d = s1_addr;
    s2_vld_d  = s2_vld;
    s2_wr_d   = s2_wr;
    s2_addr_d = s2_addr;
    if (en) begin
      s1_vld_d  = a_vld;
      s1_wr_d   = a_wr;
      s1_addr_d = a_addr;
      s2_vld_d  = s1_vld;
      s2_wr_d   = s1_wr;
      s2_addr_d = s1_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_wr   <= 1'b0;
      s1_addr <= '0;
      s2_vld  <= 1'b0;
      s2_wr   <= 1'b0;
      s2_addr <= '0;
    end else begin
      s1_vld  <= s1_vld_d;
      s1_wr   <= s1_wr_d;
      s1_addr <= s1_addr_d;
      s2_vld  <= s2_vld_d;
      s2_wr   <= s2_wr_d;
      s2_addr <= s2_addr_d;
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(s1_vld) && $stable(s2_vld) && $stable(s1_addr) && $stable(s2_wr)));

endmodule

// File: rtl/zbt_array.sv
`timescale 1ns/1ps
module zbt_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                rd_vld,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic                wr_vld,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] wbe_n,
  output logic [DATA_W-1:0]   rdata
);

  localparam int NBYTE = DATA_W / 8;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_merged;
  logic [DATA_W-1:0] rdata_d;
  logic [NBYTE-1:0]  hit;
  logic              addr_match;

  assign addr_match = (wr_addr == rd_addr);

  // bypass: bytes committed at this same edge replace the stored bytes
  for (genvar b = 0; b < NBYTE; b++) begin : g_lane
    assign hit[b] = wr_vld && addr_match && !wbe_n[b];
    assign rd_merged[b*8 +: 8] = hit[b] ? wdata[b*8 +: 8] : mem[rd_addr][b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (en && wr_vld) begin
      for (int b = 0; b < NBYTE; b++) begin
        if (!wbe_n[b]) mem[wr_addr][b*8 +: 8] <= wdata[b*8 +: 8];
      end
    end
  end

  always_comb begin
    rdata_d = rdata;
    if (en && rd_vld) rdata_d = rd_merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(rdata));

  // R11
  bypass_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rd_vld && wr_vld && addr_match && (wbe_n == '0)) |=> (rdata == $past(wdata)));

endmodule

// File: rtl/zbt_sram.sv
`timescale 1ns/1ps
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int NCS    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cen_n,
  input  logic                burst_adv,
  input  logic                we_n,
  input  logic [NCS-1:0]      cs_n,
  input  logic [DATA_W/8-1:0] be_n,
  input  logic                burst_lin,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                oe_n,
  inout  wire  [DATA_W-1:0]   dq
);

  logic              en;
  logic              a_vld, a_wr;
  logic [ADDR_W-1:0] a_addr;
  logic              s1_vld, s1_wr, s2_vld, s2_wr;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [DATA_W-1:0] rdata;
  logic              dq_oe;

  assign en = ~cen_n;

  zbt_burst_ctrl #(.ADDR_W(ADDR_W), .NCS(NCS)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .adv    (burst_adv),
    .we_n   (we_n),
    .cs_n   (cs_n),
    .addr   (addr),
    .ord    (burst_ord_e'(burst_lin)),
    .a_vld  (a_vld),
    .a_wr   (a_wr),
    .a_addr (a_addr)
  );

  zbt_pipe #(.ADDR_W(ADDR_W)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .a_vld   (a_vld),
    .a_wr    (a_wr),
    .a_addr  (a_addr),
    .s1_vld  (s1_vld),
    .s1_wr   (s1_wr),
    .s1_addr (s1_addr),
    .s2_vld  (s2_vld),
    .s2_wr   (s2_wr),
    .s2_addr (s2_addr)
  );

  zbt_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .rd_vld  (s1_vld && !s1_wr),
    .rd_addr (s1_addr),
    .wr_vld  (s2_vld && s2_wr),
    .wr_addr (s2_addr),
    .wdata   (dq),
    .wbe_n   (be_n),
    .rdata   (rdata)
  );

  // bus is driven only in a read's data slot
  assign dq_oe = s2_vld && !s2_wr && !oe_n;
  assign dq    = dq_oe ? rdata : 'z;

  // R6
  burst_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && burst_adv) |=> (s1_addr[ADDR_W-1:CNT_W] == $past(s1_addr[ADDR_W-1:CNT_W])));

endmodule

// File: tb/zbt_sram_test.sv
`timescale 1ns/1ps
module zbt_sram_test;

  localparam int AW = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        i_cen_n, i_adv, i_we_n, i_lin, i_oe_n;
  logic [2:0]  i_cs_n;
  logic [3:0]  tb_be;
  logic [AW-1:0] i_addr;
  logic        tb_oe;
  logic [31:0] tb_dat;
  tri1  [31:0] dq;

  assign dq = tb_oe ? tb_dat : 'z;

  always #4 clk = ~clk;

  zbt_sram #(.ADDR_W(AW), .DATA_W(32), .NCS(3)) uut (
    .clk(clk), .rst_n(rst_n), .cen_n(i_cen_n), .burst_adv(i_adv), .we_n(i_we_n),
    .cs_n(i_cs_n), .be_n(tb_be), .burst_lin(i_lin), .addr(i_addr), .oe_n(i_oe_n), .dq(dq)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R1";
  bit be_rand = 0;
  logic [3:0] be_pat = 4'h0;

  // bench model
  logic [31:0] mdl [32];
  logic          m_vld, m_wr;
  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;
  logic          p1_vld, p1_wr, p2_vld, p2_wr, p2_fwd;
  logic [AW-1:0] p1_addr, p2_addr;
  logic [31:0]   p2_exp;

  function automatic logic [4:0] key(input logic [AW-1:0] a);
    return {a[AW-1], a[3:0]};
  endfunction

  function automatic logic [AW-1:0] mk(input bit hi, input int lo);
    logic [AW-1:0] a;
    a = hi ? '1 : '0;
    a[3:0] = lo[3:0];
    return a;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] bn);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (!bn[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: dq=%h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic          o_vld, o_wr;
    logic [AW-1:0] o_addr;
    logic [1:0]    lo;
    if (i_cen_n) return;
    if (p2_vld && p2_wr) mdl[key(p2_addr)] = merge(mdl[key(p2_addr)], tb_dat, tb_be);
    if (!i_adv) begin
      o_vld = (i_cs_n == 3'b000); o_wr = !i_we_n; o_addr = i_addr;
      m_vld = o_vld; m_wr = o_wr; m_base = i_addr; m_cnt = 2'd0;
    end else begin
      m_cnt = m_cnt + 2'd1;
      lo = i_lin ? m_base[1:0] + m_cnt : m_base[1:0] ^ m_cnt;
      o_vld = m_vld; o_wr = m_wr; o_addr = {m_base[AW-1:2], lo};
    end
    p2_fwd = p2_vld && p2_wr && p1_vld && !p1_wr && (p2_addr == p1_addr) && (tb_be != 4'hF);
    p2_vld = p1_vld; p2_wr = p1_wr; p2_addr = p1_addr;
    if (p1_vld && !p1_wr) p2_exp = mdl[key(p1_addr)];
    p1_vld = o_vld; p1_wr = o_wr; p1_addr = o_addr;
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    if (p2_vld && p2_wr) begin
      tb_oe = 1'b1; tb_dat = $urandom; tb_be = be_rand ? 4'($urandom) : be_pat;
    end else begin
      tb_oe = 1'b0; tb_be = 4'hF;
    end
    #1;
    if (p2_vld && !p2_wr && !i_oe_n) chk(p2_fwd ? "R11" : tag, dq, p2_exp);
    else if (tb_oe) chk("R10", dq, tb_dat);
    else chk((p2_vld && !p2_wr) ? "R12" : tag, dq, 32'hFFFF_FFFF);
  endtask

  task automatic op(input bit adv, input bit we, input logic [2:0] cs, input logic [AW-1:0] a);
    i_cen_n = 1'b0; i_adv = adv; i_we_n = !we; i_cs_n = cs; i_addr = a;
    tick();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) op(1'b0, 1'b0, 3'b111, '0);
  endtask

  task automatic burst(input bit we, input logic [AW-1:0] a, input int beats);
    op(1'b0, we, 3'b000, a);
    for (int k = 1; k < beats; k++) op(1'b1, we, 3'b000, a);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, got %0d expected 0 hangs", 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C4A));
    rst_n = 1'b0; i_cen_n = 1'b0; i_adv = 1'b0; i_we_n = 1'b1; i_cs_n = 3'b111;
    i_addr = '0; i_lin = 1'b1; i_oe_n = 1'b0; tb_oe = 1'b0; tb_dat = '0; tb_be = 4'hF;
    m_vld = 0; m_wr = 0; m_base = '0; m_cnt = '0;
    p1_vld = 0; p1_wr = 0; p1_addr = '0; p2_vld = 0; p2_wr = 0; p2_addr = '0; p2_exp = '0; p2_fwd = 0;
    for (int k = 0; k < 32; k++) mdl[k] = '0;
    repeat (3) @(negedge clk);
    #1 chk("R1", dq, 32'hFFFF_FFFF);
    rst_n = 1'b1;
    // R1: advance with nothing loaded stays idle
    tag = "R1"; op(1'b1, 1'b0, 3'b000, '0); op(1'b1, 1'b0, 3'b000, '0); op(1'b1, 1'b0, 3'b000, '0);
    // R3: fill both regions with full-word linear burst writes
    tag = "R3"; i_lin = 1'b1; be_pat = 4'h0;
    for (int g = 0; g < 8; g++) burst(1'b1, mk(g >= 4, (g % 4) * 4), 4);
    idle(2);
    tag = "R2"; burst(1'b0, mk(0, 4), 4); idle(2);
    // R5 interleaved order from an unaligned start
    tag = "R5"; i_lin = 1'b0; burst(1'b0, mk(0, 1), 4); burst(1'b0, mk(1, 14), 4); idle(2);
    // R6 linear order with upper address bits set
    tag = "R6"; i_lin = 1'b1; burst(1'b0, mk(1, 6), 4); burst(1'b0, mk(0, 11), 4); idle(2);
    // R7 write burst that wraps, then a read burst that wraps
    tag = "R7"; burst(1'b1, mk(0, 9), 6); idle(2); burst(1'b0, mk(0, 10), 6); idle(2);
    // R4 partial byte masks
    tag = "R4"; be_pat = 4'b0101; op(1'b0, 1'b1, 3'b000, mk(0, 3));
    be_pat = 4'b1010; op(1'b0, 1'b1, 3'b000, mk(1, 3)); idle(2);
    op(1'b0, 1'b0, 3'b000, mk(0, 3)); op(1'b0, 1'b0, 3'b000, mk(1, 3)); idle(2); be_pat = 4'h0;
    // R8 stall mid-stream with varying inputs
    tag = "R8"; op(1'b0, 1'b0, 3'b000, mk(0, 5)); op(1'b0, 1'b1, 3'b000, mk(0, 6));
    for (int k = 0; k < 3; k++) begin
      i_cen_n = 1'b1; i_adv = k[0]; i_we_n = 1'b0; i_cs_n = 3'b000; i_addr = mk(1, k); tick();
    end
    op(1'b0, 1'b0, 3'b000, mk(0, 6)); idle(2);
    // R9 partial selects must not write
    tag = "R9";
    for (int c = 0; c < 3; c++) begin
      op(1'b0, 1'b1, 3'b001 << c, mk(0, 0)); op(1'b1, 1'b1, 3'b000, mk(0, 0));
    end
    idle(2); burst(1'b0, mk(0, 0), 2); idle(2);
    // R10 alternating reads and writes with no gap
    tag = "R10"; be_rand = 1;
    for (int k = 0; k < 10; k++) op(1'b0, k[0], 3'b000, mk(k[1], k + 2));
    idle(2);
    // R11 read directly after write, same address
    tag = "R11";
    for (int k = 0; k < 4; k++) begin
      op(1'b0, 1'b1, 3'b000, mk(1, 2 + k)); op(1'b0, 1'b0, 3'b000, mk(1, 2 + k));
    end
    idle(2);
    // R12 output enable off during a read slot
    tag = "R12"; op(1'b0, 1'b0, 3'b000, mk(0, 7)); i_oe_n = 1'b1;
    op(1'b0, 1'b0, 3'b000, mk(0, 8)); op(1'b0, 1'b0, 3'b000, mk(0, 7));
    i_oe_n = 1'b0; idle(2);
    // random mix
    tag = "R10";
    for (int n = 0; n < 4000; n++) begin
      i_cen_n = ($urandom % 100) < 8;
      i_adv   = ($urandom % 100) < 35;
      i_we_n  = 1'($urandom);
      i_cs_n  = (($urandom % 10) == 0) ? (3'b001 << ($urandom % 3)) : 3'b000;
      i_addr  = mk(1'($urandom), $urandom % 16);
      if (($urandom % 20) == 0) i_lin = !i_lin;
      i_oe_n  = ($urandom % 12) == 0;
      tick();
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule